// File: doc/BRIEF.md
# Packed Variable Funnel-Shift Unit

This block performs a per-element funnel shift on a packed vector of up to 512 bits. The vector is cut into 16-, 32- or 64-bit elements. For each element, the second-source element is placed above the current destination element. The joined double-width value is shifted right logically by a per-element count, and the low half becomes the new element. The logic is combinational, and a single output register stage holds the result.

Around this core sits the usual lane control of a SIMD execution slot:

- An optional per-element write mask, with either merging or zeroing of masked-off elements.
- An option to use count element 0 for every element (count broadcast).
- A vector-length select of 128, 256 or 512 bits. Every result bit above the selected length is cleared.

One operation is accepted per clock. Its result appears with a valid strobe on the following clock.

Top module: `vfunnel_shr`

## Requirements
- R1: For every written element j of width EW, the result is bits [EW-1:0] of the concatenation {src2[j], dst[j]} shifted right logically by the element's count.
- R2: The shift count is the count element ANDed with EW-1 (15, 31 or 63). Higher count bits have no effect on the result.
- R3: A shift count of zero returns the destination element unchanged.
- R4: Element size code `esz`: 2'b00 gives 16-bit, 2'b01 gives 32-bit and 2'b10 gives 64-bit elements. The active element count is the vector length divided by the element width.
- R5: Vector length code `vlen`: 2'b00 gives 128 bits, 2'b01 gives 256 bits and 2'b10 gives 512 bits. All result bits at or above the selected length are zero.
- R6: Element j is written with its shift result when `mask_en` is 0, or when bit j of `wmask` is 1.
- R7: A masked-off element within the vector length is zero when `zero_mode` is 1. It keeps its destination value when `zero_mode` is 0.
- R8: With `bcast` set, every 32- or 64-bit element uses count element 0. For 16-bit elements, `bcast` has no effect.
- R9: Bits of `wmask` at positions at or beyond the active element count have no effect on the result.
- R10: `out_valid` rises exactly one clock after an `in_valid` cycle and is low otherwise. A synchronous active-low reset clears `out_valid`, `err` and `result`.
- R11: An `esz` or `vlen` code of 2'b11 gives an all-zero result, with `err` high alongside `out_valid` for that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| esz | input | 2 | Element size code |
| vlen | input | 2 | Vector length code |
| wmask | input | 32 | Per-element write mask, bit j for element j |
| mask_en | input | 1 | Enables write masking |
| zero_mode | input | 1 | 1: zero masked-off elements, 0: keep them |
| bcast | input | 1 | Use count element 0 for all elements |
| dst | input | 512 | Destination operand, lower half of each funnel |
| src2 | input | 512 | Second source, upper half of each funnel |
| cnt | input | 512 | Per-element shift counts |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Shifted, masked vector |
| err | output | 1 | Unsupported size or length code |

## Verification
Random operands with random size, length, mask, merge/zero and broadcast settings are compared against a bench model that builds each result bit from the destination or source bit it must come from. This separates errors in the funnel join from errors in count masking.

Directed patterns isolate single mechanisms:
- All-zero counts show whether source bits leak into the result.
- Counts with high garbage bits show whether the count is masked to the element width.
- Broadcast with 16-bit elements shows whether the broadcast is wrongly honoured at that size.
- Masks with only out-of-range bits set show whether mask indexing respects the element count.
- A hand-computed element confirms which half of the join is the upper half.

// File: rtl/vfunnel_pkg.sv
// Shared encodings for the packed funnel-shift unit.
// Assumes 2-bit codes for element size and vector length; 2'b11 is unsupported.
package vfunnel_pkg;
    localparam int VEC_W_DEF  = 512;
    localparam int MIN_VL_DEF = 128;
    localparam int MIN_EW     = 16;

    typedef enum logic [1:0] {
        ESZ_W16 = 2'b00,
        ESZ_W32 = 2'b01,
        ESZ_W64 = 2'b10,
        ESZ_BAD = 2'b11
    } esz_t;

    typedef enum logic [1:0] {
        VL_128 = 2'b00,
        VL_256 = 2'b01,
        VL_512 = 2'b10,
        VL_BAD = 2'b11
    } vlen_t;
endpackage

// File: rtl/vfunnel_lane.sv
// One element of the funnel shifter: joins hi above lo, shifts right by sh,
// keeps the low EW bits, then applies range, write-mask and merge/zero rules.
// Assumes sh is already reduced to log2(EW) bits by the caller.
module vfunnel_lane #(
    parameter int EW = 16,
    localparam int SH_W = $clog2(EW)
) (
    input  logic [EW-1:0]   hi,
    input  logic [EW-1:0]   lo,
    input  logic [SH_W-1:0] sh,
    input  logic            wr_en,
    input  logic            zero_mode,
    input  logic            active,
    output logic [EW-1:0]   y
);
    logic [2*EW-1:0] joined_shr;

    // Double-width logical right shift of the joined pair.
    always_comb joined_shr = {hi, lo} >> sh;

    // Select shifted value, zero, or the kept destination element.
    always_comb begin
        if (!active)        y = '0;
        else if (wr_en)     y = joined_shr[EW-1:0];
        else if (zero_mode) y = '0;
        else                y = lo;
    end

    // Immediate checks of the element-level corner rules.
    always_comb begin
        if (active && wr_en && (sh == '0))
            assert_zero_count_R3: assert (y == lo);
        if (active && !wr_en && !zero_mode)
            assert_merge_keep_R7: assert (y == lo);
    end
endmodule

// File: rtl/vfunnel_array.sv
// All elements of one element width across the full vector. Picks each
// element's count (own or broadcast from element 0), its write enable from
// the mask, and whether it lies inside the selected vector length.
// Assumes vl is a valid code; the top discards results for code 2'b11.
module vfunnel_array #(
    parameter int VEC_W  = 512,
    parameter int EW     = 16,
    parameter int MIN_VL = 128,
    localparam int NE     = VEC_W / EW,
    localparam int MASK_W = VEC_W / 16,
    localparam int SH_W   = $clog2(EW),
    localparam int NE_MIN = MIN_VL / EW,
    localparam int CNT_W  = $clog2(NE) + 1,
    localparam bit BCAST_OK = (EW > 16)
) (
    input  logic [VEC_W-1:0]  dst,
    input  logic [VEC_W-1:0]  src2,
    input  logic [VEC_W-1:0]  cnt,
    input  logic [MASK_W-1:0] wmask,
    input  logic              mask_en,
    input  logic              zero_mode,
    input  logic              bcast,
    input  logic [1:0]        vl,
    output logic [VEC_W-1:0]  y
);
    logic [CNT_W-1:0] n_act;

    // Number of elements inside the selected vector length.
    always_comb n_act = CNT_W'(NE_MIN) << vl;

    for (genvar j = 0; j < NE; j++) begin : g_el
        logic [SH_W-1:0] sh_j;
        logic            act_j;
        logic            wr_j;

        // Per-element count, wired to element 0 when broadcast applies.
        always_comb begin
            if (BCAST_OK && bcast) sh_j = cnt[SH_W-1:0];
            else                   sh_j = cnt[j*EW +: SH_W];
            act_j = (CNT_W'(j) < n_act);
            wr_j  = !mask_en || wmask[j];
        end

        vfunnel_lane #(.EW(EW)) u_lane (
            .hi       (src2[j*EW +: EW]),
            .lo       (dst[j*EW +: EW]),
            .sh       (sh_j),
            .wr_en    (wr_j),
            .zero_mode(zero_mode),
            .active   (act_j),
            .y        (y[j*EW +: EW])
        );
    end
endmodule

// File: rtl/vfunnel_shr.sv
// Packed variable funnel-shift unit, top level. Builds one element array per
// supported width, selects by esz, and registers result, valid and error.
// Assumes one operation per in_valid cycle; no backpressure.
module vfunnel_shr
    import vfunnel_pkg::*;
#(
    parameter int VEC_W  = VEC_W_DEF,
    parameter int MIN_VL = MIN_VL_DEF,
    localparam int MASK_W = VEC_W / MIN_EW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        esz,
    input  logic [1:0]        vlen,
    input  logic [MASK_W-1:0] wmask,
    input  logic              mask_en,
    input  logic              zero_mode,
    input  logic              bcast,
    input  logic [VEC_W-1:0]  dst,
    input  logic [VEC_W-1:0]  src2,
    input  logic [VEC_W-1:0]  cnt,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result,
    output logic              err
);
    logic [VEC_W-1:0] res_w [3];
    logic [VEC_W-1:0] pick;
    logic             bad_code;

    for (genvar g = 0; g < 3; g++) begin : g_w
        vfunnel_array #(.VEC_W(VEC_W), .EW(MIN_EW << g), .MIN_VL(MIN_VL)) u_arr (
            .dst      (dst),
            .src2     (src2),
            .cnt      (cnt),
            .wmask    (wmask),
            .mask_en  (mask_en),
            .zero_mode(zero_mode),
            .bcast    (bcast),
            .vl       (vlen),
            .y        (res_w[g])
        );
    end

    // Choose the array matching the element size; flag unsupported codes.
    always_comb begin
        bad_code = (esz == ESZ_BAD) || (vlen == VL_BAD);
        case (esz)
            ESZ_W16: pick = res_w[0];
            ESZ_W32: pick = res_w[1];
            ESZ_W64: pick = res_w[2];
            default: pick = '0;
        endcase
    end

    // Output register stage: one-cycle latency, error only with its result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            err       <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                err    <= bad_code;
                result <= bad_code ? '0 : pick;
            end else begin
                err    <= 1'b0;
            end
        end
    end

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    assert_err_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (out_valid && (result == '0)));

    assert_bad_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(esz) == ESZ_BAD)) |-> err);

    assert_above_128_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(vlen) == VL_128))
            |-> (result[VEC_W-1:MIN_VL] == '0));

    assert_above_256_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(vlen) == VL_256))
            |-> (result[VEC_W-1:2*MIN_VL] == '0));
endmodule

// File: tb/test_vfunnel_shr.sv
`timescale 1ns/1ps
module test_vfunnel_shr;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   esz, vlen;
    logic [31:0]  wmask;
    logic         mask_en, zero_mode, bcast;
    logic [511:0] dst, src2, cnt;
    logic         out_valid, err;
    logic [511:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vfunnel_shr i_vfunnel_shr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .esz(esz), .vlen(vlen),
        .wmask(wmask), .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
        .dst(dst), .src2(src2), .cnt(cnt),
        .out_valid(out_valid), .result(result), .err(err)
    );

    // Reference: each output bit taken from the dst or src2 bit it must come from.
    function automatic logic [511:0] model(int ec, int vc, logic [31:0] m, bit men,
            bit zm, bit bc, logic [511:0] d, logic [511:0] s, logic [511:0] c);
        logic [511:0] r = '0;
        int ew, ne, base, csrc, sh, idx;
        if (ec == 3 || vc == 3) return r;
        ew = 16 << ec;
        ne = (128 << vc) / ew;
        for (int j = 0; j < ne; j++) begin
            base = j * ew;
            csrc = (bc && ew != 16) ? 0 : base;
            sh   = int'(c[csrc +: 6]) & (ew - 1);
            if (!men || m[j]) begin
                for (int b = 0; b < ew; b++) begin
                    idx = b + sh;
                    r[base + b] = (idx < ew) ? d[base + idx] : s[base + idx - ew];
                end
            end else if (!zm) begin
                for (int b = 0; b < ew; b++) r[base + b] = d[base + b];
            end
        end
        return r;
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(string tag, int ec, int vc, logic [31:0] m, bit men, bit zm,
            bit bc, logic [511:0] d, logic [511:0] s, logic [511:0] c);
        @(negedge clk);
        esz = 2'(ec); vlen = 2'(vc); wmask = m; mask_en = men; zero_mode = zm;
        bcast = bc; dst = d; src2 = s; cnt = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " result"}, result, model(ec, vc, m, men, zm, bc, d, s, c));
        chk("R10 out_valid", {511'd0, out_valid}, 512'd1);
        chk("R11 err", {511'd0, err}, {511'd0, (ec == 3 || vc == 3)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [511:0] d, s, c, c2;
        void'($urandom(32'd5150));
        rst_n = 1'b0; in_valid = 1'b0; esz = 0; vlen = 0; wmask = 0;
        mask_en = 0; zero_mode = 0; bcast = 0; dst = 0; src2 = 0; cnt = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset out_valid", {511'd0, out_valid}, 512'd0);
        chk("R10 reset err", {511'd0, err}, 512'd0);
        chk("R10 reset result", result, 512'd0);
        rst_n = 1'b1;

        // R1: hand-computed element, {ABCD,1234} >> 4 -> D123
        d = '0; s = '0; c = '0;
        d[15:0] = 16'h1234; s[15:0] = 16'hABCD; c[15:0] = 16'd4;
        run_op("R1 known", 0, 0, '0, 0, 0, 0, d, s, c);
        chk("R1 element0", {496'd0, result[15:0]}, {496'd0, 16'hD123});

        // R3: zero counts return dst, 32-bit, 512-bit length
        d = rnd512(); s = rnd512();
        run_op("R3 zero count", 1, 2, '0, 0, 0, 0, d, s, '0);
        chk("R3 equals dst", result, d);

        // R2: counts with high garbage act like count 3 (16-bit)
        c = '0; c2 = '0;
        for (int j = 0; j < 32; j++) begin
            c[j*16 +: 16] = 16'hFFF3; c2[j*16 +: 16] = 16'h0003;
        end
        run_op("R2 high bits", 0, 2, '0, 0, 0, 0, d, s, c);
        chk("R2 same as 3", result, model(0, 2, '0, 0, 0, 0, d, s, c2));

        // R8: broadcast ignored for 16-bit, honoured for 64-bit
        c = rnd512();
        run_op("R8 bcast16", 0, 2, '0, 0, 0, 1, d, s, c);
        chk("R8 bcast16 no effect", result, model(0, 2, '0, 0, 0, 0, d, s, c));
        c2 = '0;
        for (int j = 0; j < 8; j++) c2[j*64 +: 64] = c[63:0];
        run_op("R8 bcast64", 2, 2, '0, 0, 0, 1, d, s, c);
        chk("R8 bcast64 uses elem0", result, model(2, 2, '0, 0, 0, 0, d, s, c2));

        // R5 / R4: 128-bit length with 64-bit elements leaves upper bits zero
        run_op("R5 vl128", 2, 0, '0, 0, 0, 0, d, s, c);
        chk("R5 upper zero", {128'd0, result[511:128]}, 512'd0);

        // R6 / R7: alternating mask, merge then zero
        run_op("R7 merge", 1, 2, 32'h0000_5A5A, 1, 0, 0, d, s, c);
        run_op("R7 zero", 1, 2, 32'h0000_5A5A, 1, 1, 0, d, s, c);
        run_op("R6 mask off", 0, 1, 32'h1234_8001, 0, 1, 0, d, s, c);

        // R9: only mask bits beyond element count set -> all four masked off
        run_op("R9 far bits", 1, 0, 32'hFFFF_FFF0, 1, 0, 0, d, s, c);
        chk("R9 low kept", {384'd0, result[127:0]}, {384'd0, d[127:0]});

        // R11: unsupported codes
        run_op("R11 esz bad", 3, 1, '0, 0, 0, 0, d, s, c);
        run_op("R11 vlen bad", 0, 3, '0, 0, 0, 0, d, s, c);

        // R10: idle cycle drops out_valid
        @(negedge clk);
        chk("R10 idle out_valid", {511'd0, out_valid}, 512'd0);

        // R1 / R4: random mix
        for (int n = 0; n < 400; n++) begin
            run_op("R1 random", int'($urandom % 4), int'($urandom % 4), $urandom,
                   1'($urandom), 1'($urandom), 1'($urandom), rnd512(), rnd512(), rnd512());
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule